// File: doc/BRIEF.md
# Superscalar Register Rename Stage

This block renames a group of up to `IW` instructions in one clock cycle. Each slot of the group carries two logical source registers and one logical destination register. Slot 0 is the oldest instruction of the group. Source registers are translated to physical registers through a table that holds one physical id per logical register. Every valid destination takes the next physical id from a FIFO pool of free registers.

A source can name a register that an older slot of the same group writes. In that case the block returns the physical id just given to that slot, not the stale table value. If several older slots write that register, the youngest of them supplies the id.

A small chain of table snapshots lets the pipeline undo speculative renames. A snapshot request pushes the current table into the head of the chain and moves the older copies one place down. A rollback request copies any chosen snapshot back into the live table in one cycle. Registers that retire come back through a single release port and are appended to the tail of the pool.

Top module: `rename_stage`

## Requirements
- R1: After reset, logical register n maps to physical register n for every n in 0..31. The pool holds physical ids 32 to 127, in ascending order from the head.
- R2: A valid slot's two source outputs give the table entry of their 5-bit logical register, unless R4 applies. Each output is a 7-bit physical id.
- R3: When the group is accepted, the valid slots take consecutive ids from the pool head in slot order, with slot 0 taking the first. The physical destination appears on `phys_d_o` in the same cycle. No two slots of a group receive the same id.
- R4: A source that matches the logical destination of a valid, older slot in the same group gets the physical id allocated to the youngest such slot. It does not get the table entry.
- R5: After an accepted group, each written logical register maps to the id of the youngest valid slot that named it as destination.
- R6: A valid group whose count of valid slots exceeds the number of free ids is not accepted: `fire_o` is 0 and `stall_o` is 1. The table and the pool are unchanged. A group needing exactly the free count is accepted.
- R7: A release appends its id to the pool tail, and that id is handed out after all ids already in the pool. A release in a cycle where the pool is empty cannot serve that same cycle's group.
- R8: A snapshot request writes the table into snapshot 0 as it stands after that cycle's group. Snapshot k then takes the previous content of snapshot k-1.
- R9: A rollback copies snapshot `rollback_sel_i` into the table in one cycle. The group offered in that cycle is not accepted, and a snapshot request in that cycle is ignored.
- R10: An invalid slot takes no id and drives 0 on `phys_d_o`. Its destination is never used to redirect a younger slot's source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_vld_i | input | 1 | A group is offered this cycle |
| slot_vld_i | input | IW | Per-slot valid; bit 0 is the oldest slot |
| src_a_i | input | IW*LW | First logical source per slot, slot i at bits i*LW |
| src_b_i | input | IW*LW | Second logical source per slot |
| dst_i | input | IW*LW | Logical destination per slot |
| phys_a_o | output | IW*PW | Physical id of first source per slot |
| phys_b_o | output | IW*PW | Physical id of second source per slot |
| phys_d_o | output | IW*PW | Newly allocated physical destination per slot |
| fire_o | output | 1 | Group accepted this cycle |
| stall_o | output | 1 | Group offered but not accepted |
| rel_vld_i | input | 1 | Return one physical id to the pool |
| rel_id_i | input | PW | Id being returned |
| snap_i | input | 1 | Push the table into the snapshot chain |
| rollback_i | input | 1 | Restore the table from a snapshot |
| rollback_sel_i | input | SW | Snapshot index to restore, 0 is the newest |

## Verification
Several internal faults are invisible in the cycle they happen. A corrupted table entry, a misplaced pool head or a wrong snapshot shows up only when a later group reads that register or draws that id. The bench therefore reads back, in the very next group, every register a scenario has written, restored or left untouched by a stall. A wrong free count shows up as a stall one group too early or one group too late at the point where the pool runs dry, so that boundary is driven with exactly the number of free ids. A bypass fault is visible at once on the source outputs of the same cycle.

// File: rtl/rename_stage.sv
module rename_stage #(
  parameter int IW  = 4,
  parameter int LW  = 5,
  parameter int PW  = 7,
  parameter int CKD = 4,
  localparam int SW = (CKD > 1) ? $clog2(CKD) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            grp_vld_i,
  input  logic [IW-1:0]   slot_vld_i,
  input  logic [IW*LW-1:0] src_a_i,
  input  logic [IW*LW-1:0] src_b_i,
  input  logic [IW*LW-1:0] dst_i,
  output logic [IW*PW-1:0] phys_a_o,
  output logic [IW*PW-1:0] phys_b_o,
  output logic [IW*PW-1:0] phys_d_o,
  output logic            fire_o,
  output logic            stall_o,
  input  logic            rel_vld_i,
  input  logic [PW-1:0]   rel_id_i,
  input  logic            snap_i,
  input  logic            rollback_i,
  input  logic [SW-1:0]   rollback_sel_i
);
  localparam int NLOG = 1 << LW;
  localparam int NPHYS = 1 << PW;
  localparam int POOL = NPHYS - NLOG;
  localparam int CW = $clog2(POOL + 1);
  localparam int PTRW = $clog2(POOL);
  localparam int NW = $clog2(IW + 1);

  logic [PW-1:0]   map_q  [NLOG];
  logic [PW-1:0]   map_nx [NLOG];
  logic [PW-1:0]   ckpt_q [CKD][NLOG];
  logic [PW-1:0]   pool_q [POOL];
  logic [PTRW-1:0] head_q, tail_q;
  logic [CW-1:0]   cnt_q;
  logic [NW-1:0]   need;
  logic [PW-1:0]   alloc [IW];

  function automatic int wrap(input int x);
    return (x >= POOL) ? x - POOL : x;
  endfunction

  always_comb begin
    need = '0;
    for (int i = 0; i < IW; i++) need = need + NW'(slot_vld_i[i]);
  end

  assign fire_o  = grp_vld_i && !rollback_i && (int'(need) <= int'(cnt_q));
  assign stall_o = grp_vld_i && !fire_o;

  always_comb begin
    int k;
    k = 0;
    for (int i = 0; i < IW; i++) begin
      alloc[i] = pool_q[PTRW'(wrap(int'(head_q) + k))];
      if (slot_vld_i[i]) k = k + 1;
    end
  end

  always_comb begin
    for (int i = 0; i < IW; i++) begin
      logic [PW-1:0] pa, pb;
      pa = map_q[src_a_i[i*LW +: LW]];
      pb = map_q[src_b_i[i*LW +: LW]];
      for (int j = 0; j < IW; j++) begin
        if (j < i && slot_vld_i[j] && dst_i[j*LW +: LW] == src_a_i[i*LW +: LW]) pa = alloc[j];
        if (j < i && slot_vld_i[j] && dst_i[j*LW +: LW] == src_b_i[i*LW +: LW]) pb = alloc[j];
      end
      phys_a_o[i*PW +: PW] = pa;
      phys_b_o[i*PW +: PW] = pb;
      phys_d_o[i*PW +: PW] = slot_vld_i[i] ? alloc[i] : '0;
    end
  end

  always_comb begin
    map_nx = map_q;
    if (fire_o)
      for (int i = 0; i < IW; i++)
        if (slot_vld_i[i]) map_nx[dst_i[i*LW +: LW]] = alloc[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int n = 0; n < NLOG; n++) begin
        map_q[n] <= PW'(n);
        for (int c = 0; c < CKD; c++) ckpt_q[c][n] <= PW'(n);
      end
      for (int p = 0; p < POOL; p++) pool_q[p] <= PW'(NLOG + p);
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= CW'(POOL);
    end else begin
      if (rollback_i) begin
        map_q <= ckpt_q[rollback_sel_i];
      end else begin
        map_q <= map_nx;
        if (snap_i) begin
          ckpt_q[0] <= map_nx;
          for (int c = 1; c < CKD; c++) ckpt_q[c] <= ckpt_q[c-1];
        end
      end
      if (fire_o) head_q <= PTRW'(wrap(int'(head_q) + int'(need)));
      if (rel_vld_i) begin
        pool_q[tail_q] <= rel_id_i;
        tail_q <= PTRW'(wrap(int'(tail_q) + 1));
      end
      cnt_q <= cnt_q - (fire_o ? CW'(need) : CW'(0)) + CW'(rel_vld_i);
    end
  end

  p_rollback_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rollback_i |-> !fire_o);

  p_stall_holds_pool_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_o && !rel_vld_i) |=> $stable(cnt_q) && $stable(head_q));

  p_count_tracks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> int'(cnt_q) == int'($past(cnt_q)) - int'($past(need)) + int'($past(rel_vld_i)));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rel_vld_i |-> int'(cnt_q) < POOL);

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= POOL);

  always @(posedge clk)
    if (rst_n && fire_o)
      for (int i = 0; i < IW; i++)
        for (int j = 0; j < IW; j++)
          if (i < j && slot_vld_i[i] && slot_vld_i[j])
            p_alloc_unique_r3: assert (phys_d_o[i*PW +: PW] != phys_d_o[j*PW +: PW]);
endmodule

// File: tb/rename_stage_test.sv
`timescale 1ns/1ps
module rename_stage_test;
  localparam int IW = 4, LW = 5, PW = 7, CKD = 4;
  logic clk = 0, rst_n = 0;
  logic grp_vld_i = 0, rel_vld_i = 0, snap_i = 0, rollback_i = 0;
  logic [IW-1:0] slot_vld_i = '0;
  logic [IW*LW-1:0] src_a_i = '0, src_b_i = '0, dst_i = '0;
  logic [IW*PW-1:0] phys_a_o, phys_b_o, phys_d_o;
  logic fire_o, stall_o;
  logic [PW-1:0] rel_id_i = '0;
  logic [1:0] rollback_sel_i = '0;

  rename_stage #(.IW(IW), .LW(LW), .PW(PW), .CKD(CKD)) uut (.*);

  always #2.5 clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 0;
  int mmap[32];
  int mck[CKD][32];
  int q[$];
  int ga[IW], gb[IW], gd[IW];
  logic [IW-1:0] gv;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycle(bit grp, bit snap, bit rb, int sel, bit rel, int relid, string req);
    int tmp[32];
    int ea[IW], eb[IW], ed[IW];
    int need, k;
    bit efire;
    grp_vld_i = grp; slot_vld_i = gv; snap_i = snap; rollback_i = rb;
    rollback_sel_i = 2'(sel); rel_vld_i = rel; rel_id_i = PW'(relid);
    for (int i = 0; i < IW; i++) begin
      src_a_i[i*LW +: LW] = LW'(ga[i]);
      src_b_i[i*LW +: LW] = LW'(gb[i]);
      dst_i[i*LW +: LW]   = LW'(gd[i]);
    end
    need = $countones(gv);
    efire = grp && !rb && need <= q.size();
    tmp = mmap; k = 0;
    for (int i = 0; i < IW; i++) begin
      ea[i] = tmp[ga[i]]; eb[i] = tmp[gb[i]]; ed[i] = 0;
      if (gv[i] && efire) begin
        ed[i] = q[k]; k++; tmp[gd[i]] = ed[i];
      end
    end
    #1;
    chk({req, " fire"}, int'(fire_o), int'(efire));
    chk({req, " stall"}, int'(stall_o), int'(grp && !efire));
    if (efire)
      for (int i = 0; i < IW; i++) begin
        chk({req, " src a"}, int'(phys_a_o[i*PW +: PW]), ea[i]);
        chk({req, " src b"}, int'(phys_b_o[i*PW +: PW]), eb[i]);
        chk({req, " dst"}, int'(phys_d_o[i*PW +: PW]), ed[i]);
      end
    @(posedge clk);
    if (rb) mmap = mck[sel];
    else begin
      if (efire) begin mmap = tmp; for (int i = 0; i < k; i++) void'(q.pop_front()); end
      if (snap) begin
        for (int c = CKD-1; c > 0; c--) mck[c] = mck[c-1];
        mck[0] = mmap;
      end
    end
    if (rel) q.push_back(relid);
    #1;
    grp_vld_i = 0; snap_i = 0; rollback_i = 0; rel_vld_i = 0;
  endtask

  task automatic set(logic [IW-1:0] v, int a0, int b0, int d0, int a1, int b1, int d1,
                     int a2, int b2, int d2, int a3, int b3, int d3);
    gv = v;
    ga = '{a0, a1, a2, a3}; gb = '{b0, b1, b2, b3}; gd = '{d0, d1, d2, d3};
  endtask

  task automatic t_reset();
    set(4'b1111, 0, 1, 8, 2, 3, 9, 4, 5, 10, 6, 31, 11);
    cycle(1, 0, 0, 0, 0, 0, "R1 R2 R3 reset map and pool");
    chk("R1 first pool id", int'(mmap[8]), 32);
  endtask

  task automatic t_bypass();
    set(4'b1111, 1, 3, 1, 1, 2, 2, 2, 1, 1, 1, 2, 3);
    cycle(1, 0, 0, 0, 0, 0, "R4 intra-group bypass");
    set(4'b1111, 1, 2, 20, 3, 3, 21, 8, 9, 22, 10, 11, 23);
    cycle(1, 0, 0, 0, 0, 0, "R5 youngest writer in table");
  endtask

  task automatic t_invalid();
    set(4'b0101, 4, 4, 4, 6, 6, 5, 5, 4, 6, 7, 7, 7);
    cycle(1, 0, 0, 0, 0, 0, "R10 invalid slot no bypass");
    set(4'b1111, 5, 6, 24, 4, 7, 25, 0, 0, 26, 0, 0, 27);
    cycle(1, 0, 0, 0, 0, 0, "R10 invalid slot no table write");
  endtask

  task automatic t_ckpt();
    set(4'b0011, 0, 0, 12, 0, 0, 13, 0, 0, 0, 0, 0, 0);
    cycle(1, 1, 0, 0, 0, 0, "R8 snapshot after group");
    set(4'b0001, 0, 0, 12, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cycle(1, 1, 0, 0, 0, 0, "R8 second snapshot");
    set(4'b0011, 0, 0, 12, 0, 0, 13, 0, 0, 0, 0, 0, 0);
    cycle(1, 0, 0, 0, 0, 0, "R8 overwrite after snapshot");
    set(4'b1111, 12, 13, 14, 12, 13, 15, 0, 0, 16, 0, 0, 17);
    cycle(1, 1, 1, 1, 0, 0, "R9 rollback older snapshot blocks group");
    set(4'b1111, 12, 13, 18, 14, 15, 19, 16, 17, 28, 0, 0, 29);
    cycle(1, 0, 0, 0, 0, 0, "R9 restored table read");
    chk("R9 restored r12 from older snapshot", mmap[12], mck[1][12]);
    set(4'b0001, 0, 0, 12, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cycle(1, 0, 1, 0, 0, 0, "R9 rollback newest");
    set(4'b0011, 12, 13, 30, 14, 15, 31, 0, 0, 0, 0, 0, 0);
    cycle(1, 0, 0, 0, 0, 0, "R9 newest snapshot read");
  endtask

  task automatic t_drain();
    int n;
    while (q.size() >= 4) begin
      set(4'b1111, 1, 2, 3, 3, 4, 5, 5, 6, 7, 7, 8, 9);
      cycle(1, 0, 0, 0, 0, 0, "R3 drain");
    end
    n = q.size();
    set(4'b1111, 1, 3, 2, 2, 5, 4, 4, 7, 6, 6, 9, 8);
    cycle(1, 0, 0, 0, 0, 0, "R6 stall when short");
    gv = 4'((1 << n) - 1);
    cycle(1, 0, 0, 0, 0, 0, "R6 exact count fires");
    chk("R6 pool empty", q.size(), 0);
    set(4'b0001, 2, 3, 10, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cycle(1, 0, 0, 0, 1, 40, "R7 release cannot serve same cycle");
    cycle(0, 0, 0, 0, 1, 41, "R7 second release");
    set(4'b0011, 2, 3, 10, 10, 9, 11, 0, 0, 0, 0, 0, 0);
    cycle(1, 0, 0, 0, 0, 0, "R7 released ids in order");
    set(4'b0001, 10, 11, 12, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cycle(1, 0, 0, 0, 0, 0, "R6 stall after reuse");
    chk("R7 last id 41", mmap[11], 41);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 32; n++) begin
      mmap[n] = n;
      for (int c = 0; c < CKD; c++) mck[c][n] = n;
    end
    for (int p = 32; p < 128; p++) q.push_back(p);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;
    chk("R1 idle no fire", int'(fire_o), 0);
    t_reset();
    t_bypass();
    t_invalid();
    t_ckpt();
    t_drain();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule